// File: doc/BRIEF.md
# Peripheral Reset Fan-Out Controller

This block sits behind a write-only reset-control register in a chip's system control space. Software writes one 32-bit word. The block turns that word into one active-high reset pulse per on-chip peripheral and, when asked, a request to reset the whole chip. Each low-order bit of the word names one peripheral. Two group bits stand for fixed sets of peripherals. The register keeps no state, so a read always returns zero.

The two groups are not the same. The peripheral group clears every peripheral except the two GPIO ports, and it includes watchdog 0. The soft group swaps those: it leaves watchdog 0 alone and clears both GPIO ports. When either group bit is present, its set replaces the individually written bits. If both group bits are present, the soft group wins. The whole-system request does not depend on the rest of the word. Every output is a registered pulse that lasts exactly one clock, in the cycle after the write.

Top module: `rstfan_ctrl`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released with no write, every `periph_rst_o` bit and `sys_rst_req_o` are 0.
- R2: A write with bit 31 set drives `sys_rst_req_o` high for exactly the next cycle. A write with bit 31 clear leaves it low.
- R3: A write with bit 29 set and bit 30 clear pulses peripheral indices 0 to 14 in the next cycle: UART0..2 = 0..2, ADC = 3, CNN = 4, TRNG = 5, RTC = 6, I2C0 = 7, SPI1 = 8, TMR0..3 = 9..12, WDT0 = 13, DMA = 14. Both GPIO ports (indices 15 and 16) stay low, which is mask 0x07FFF.
- R4: A write with bit 30 set pulses the R3 set without WDT0 (index 13) but with GPIO0 and GPIO1 (indices 15, 16), which is mask 0x1DFFF.
- R5: When a group bit is set, the low-order bits of the written word have no effect on `periph_rst_o`. When bits 30 and 29 are both set, the R4 set is produced.
- R6: A write with bits 30 and 29 clear pulses exactly the peripherals whose index bit (0 to 16) is set in the word, and no others.
- R7: Bits 17 to 28 of the written word never affect any output.
- R8: Every reset output is a one-cycle pulse. In the cycle after a clock edge with `wr_en_i` low, all reset outputs are 0.
- R9: `rd_data_o` is 0 at all times, including right after any write.
- R10: The whole-system request and the peripheral pulses are independent. Bit 31 combined with a group bit or with individual bits produces both effects in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the reset-control word |
| wr_data_i | input | 32 | Written reset-control word |
| rd_data_o | output | 32 | Read value of the register, always zero |
| periph_rst_o | output | 17 | One-cycle reset pulse per peripheral, indexed as in R3/R4 |
| sys_rst_req_o | output | 1 | One-cycle whole-chip reset request |

## Verification
The bench goes after four corner cases.

- **Both group bits set together.** A design with the priority reversed would give the watchdog-including set 0x07FFF instead of 0x1DFFF.
- **Group bits with random low-order noise.** A design that ORs the expansion with the written bits, instead of replacing them, would leak extra pulses.
- **Bits 17 to 28 set.** A decoder with the wrong field width would react to them.
- **Back-to-back writes followed by idle cycles.** A design that stretches its pulses, or fails to drop them, would show nonzero outputs when no write came before.

On top of these, random words with the system bit mixed in check that the whole-chip request never masks or is masked by the peripheral fan-out.

// File: rtl/rstfan_pkg.sv
package rstfan_pkg;

   // Peripheral index map; the position of each entry is the output bit it drives.
   typedef enum int unsigned {
      PR_UART0 = 0,  PR_UART1 = 1,  PR_UART2 = 2,  PR_ADC  = 3,
      PR_CNN   = 4,  PR_TRNG  = 5,  PR_RTC   = 6,  PR_I2C0 = 7,
      PR_SPI1  = 8,  PR_TMR0  = 9,  PR_TMR1  = 10, PR_TMR2 = 11,
      PR_TMR3  = 12, PR_WDT0  = 13, PR_DMA   = 14, PR_GPIO0 = 15,
      PR_GPIO1 = 16
   } periph_idx_e;

   localparam int unsigned DEF_N_PERIPH = 17;
   localparam int unsigned DEF_DATA_W   = 32;

   // Group bit positions inside the written word.
   localparam int unsigned DEF_SYS_BIT  = 31;
   localparam int unsigned DEF_SOFT_BIT = 30;
   localparam int unsigned DEF_PER_BIT  = 29;

   // Set cleared by the peripheral group: everything except the GPIO ports.
   function automatic logic [DEF_N_PERIPH-1:0] per_group_mask();
      logic [DEF_N_PERIPH-1:0] m;
      m = '1;
      m[PR_GPIO0] = 1'b0;
      m[PR_GPIO1] = 1'b0;
      return m;
   endfunction

   // Set cleared by the soft group: GPIO ports in, watchdog 0 out.
   function automatic logic [DEF_N_PERIPH-1:0] soft_group_mask();
      logic [DEF_N_PERIPH-1:0] m;
      m = per_group_mask();
      m[PR_WDT0]  = 1'b0;
      m[PR_GPIO0] = 1'b1;
      m[PR_GPIO1] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/rstfan_expand.sv
// Combinational group expansion: picks the soft set, the peripheral set,
// or the individually written bits, per output.
module rstfan_expand #(
   parameter int unsigned          N_PERIPH  = rstfan_pkg::DEF_N_PERIPH,
   parameter int unsigned          DATA_W    = rstfan_pkg::DEF_DATA_W,
   parameter int unsigned          SOFT_BIT  = rstfan_pkg::DEF_SOFT_BIT,
   parameter int unsigned          PER_BIT   = rstfan_pkg::DEF_PER_BIT,
   parameter logic [N_PERIPH-1:0]  SOFT_MASK = rstfan_pkg::soft_group_mask(),
   parameter logic [N_PERIPH-1:0]  PER_MASK  = rstfan_pkg::per_group_mask()
) (
   input  logic [DATA_W-1:0]   word_i,
   output logic [N_PERIPH-1:0] sel_o
);

   logic soft_hit;
   logic per_hit;

   assign soft_hit = word_i[SOFT_BIT];
   assign per_hit  = word_i[PER_BIT];

   // Elaboration checks on the field layout.
   if (N_PERIPH == 0) begin : g_chk_n
      $error("rstfan_expand: N_PERIPH must be nonzero");
   end
   if (SOFT_BIT >= DATA_W || PER_BIT >= DATA_W) begin : g_chk_range
      $error("rstfan_expand: group bit outside the word");
   end
   if (SOFT_BIT == PER_BIT) begin : g_chk_dup
      $error("rstfan_expand: group bits must differ");
   end
   if (N_PERIPH > PER_BIT || N_PERIPH > SOFT_BIT) begin : g_chk_overlap
      $error("rstfan_expand: peripheral field overlaps a group bit");
   end

   // One selector per peripheral; soft group has priority over peripheral group.
   for (genvar gi = 0; gi < int'(N_PERIPH); gi++) begin : g_sel
      always_comb begin
         if (soft_hit) begin
            sel_o[gi] = SOFT_MASK[gi];
         end else if (per_hit) begin
            sel_o[gi] = PER_MASK[gi];
         end else begin
            sel_o[gi] = word_i[gi];
         end
      end
   end

   // Low-order bits above the peripheral field, and the remaining high bits, are not decoded.
   logic unused_word_bits;
   assign unused_word_bits = ^word_i;

endmodule

// File: rtl/rstfan_pulse.sv
// Registered one-cycle pulse stage: output equals the gated request of the
// previous cycle and falls back to zero when nothing is requested.
module rstfan_pulse #(
   parameter int unsigned W = 1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         fire_i,
   input  logic [W-1:0] req_i,
   output logic [W-1:0] pulse_o
);

   if (W == 0) begin : g_chk_w
      $error("rstfan_pulse: width must be nonzero");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pulse_o <= '0;
      end else if (fire_i) begin
         pulse_o <= req_i;
      end else begin
         pulse_o <= '0;
      end
   end

   // R8: a pulse stage never holds a value through a cycle without a fire.
   a_r8_pulse_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fire_i |=> (pulse_o == '0));

endmodule

// File: rtl/rstfan_ctrl.sv
module rstfan_ctrl #(
   parameter int unsigned N_PERIPH = rstfan_pkg::DEF_N_PERIPH,
   parameter int unsigned DATA_W   = rstfan_pkg::DEF_DATA_W,
   parameter int unsigned SYS_BIT  = rstfan_pkg::DEF_SYS_BIT,
   parameter int unsigned SOFT_BIT = rstfan_pkg::DEF_SOFT_BIT,
   parameter int unsigned PER_BIT  = rstfan_pkg::DEF_PER_BIT,
   parameter logic [N_PERIPH-1:0] SOFT_MASK = rstfan_pkg::soft_group_mask(),
   parameter logic [N_PERIPH-1:0] PER_MASK  = rstfan_pkg::per_group_mask()
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                wr_en_i,
   input  logic [DATA_W-1:0]   wr_data_i,
   output logic [DATA_W-1:0]   rd_data_o,
   output logic [N_PERIPH-1:0] periph_rst_o,
   output logic                sys_rst_req_o
);

   localparam int unsigned OUT_W = N_PERIPH + 1;

   if (SYS_BIT >= DATA_W) begin : g_chk_sys
      $error("rstfan_ctrl: system bit outside the word");
   end
   if (SYS_BIT == SOFT_BIT || SYS_BIT == PER_BIT) begin : g_chk_sys_dup
      $error("rstfan_ctrl: system bit collides with a group bit");
   end
   if (N_PERIPH > SYS_BIT) begin : g_chk_sys_ovl
      $error("rstfan_ctrl: peripheral field overlaps the system bit");
   end

   logic [N_PERIPH-1:0] sel;
   logic [OUT_W-1:0]    req;
   logic [OUT_W-1:0]    pulse;

   rstfan_expand #(
      .N_PERIPH  (N_PERIPH),
      .DATA_W    (DATA_W),
      .SOFT_BIT  (SOFT_BIT),
      .PER_BIT   (PER_BIT),
      .SOFT_MASK (SOFT_MASK),
      .PER_MASK  (PER_MASK)
   ) expand_i (
      .word_i (wr_data_i),
      .sel_o  (sel)
   );

   assign req = {wr_data_i[SYS_BIT], sel};

   rstfan_pulse #(
      .W (OUT_W)
   ) pulse_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .fire_i  (wr_en_i),
      .req_i   (req),
      .pulse_o (pulse)
   );

   assign periph_rst_o  = pulse[N_PERIPH-1:0];
   assign sys_rst_req_o = pulse[N_PERIPH];

   // The control word is write-only in effect; nothing is stored for read-back.
   assign rd_data_o = '0;

   // R2 / R10: system request follows the system bit of the written word.
   a_r2_sys_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> (sys_rst_req_o == $past(wr_data_i[SYS_BIT])));

   // R4 / R5: soft group wins, even when the peripheral group bit is also set.
   a_r4_soft_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_data_i[SOFT_BIT]) |=> (periph_rst_o == SOFT_MASK));

   // R3: peripheral group alone.
   a_r3_per_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_data_i[PER_BIT] && !wr_data_i[SOFT_BIT])
      |=> (periph_rst_o == PER_MASK));

   // R6: no group bit, each set bit hits only its own peripheral.
   a_r6_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !wr_data_i[PER_BIT] && !wr_data_i[SOFT_BIT])
      |=> (periph_rst_o == $past(wr_data_i[N_PERIPH-1:0])));

   // R8: no write, no system request in the next cycle.
   a_r8_sys_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> !sys_rst_req_o);

endmodule

// File: tb/rstfan_ctrl_tb.sv
`timescale 1ns/1ps
module rstfan_ctrl_tb_top;

   localparam int unsigned NP = 17;
   localparam logic [NP-1:0] PER_M  = 17'h07FFF;
   localparam logic [NP-1:0] SOFT_M = 17'h1DFFF;

   logic          clk = 1'b0;
   logic          rst_ni = 1'b0;
   logic          wr_en = 1'b0;
   logic [31:0]   wr_data = '0;
   logic [31:0]   rd_data;
   logic [NP-1:0] prst;
   logic          sreq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   rstfan_ctrl dut_i (
      .clk_i         (clk),
      .rst_ni        (rst_ni),
      .wr_en_i       (wr_en),
      .wr_data_i     (wr_data),
      .rd_data_o     (rd_data),
      .periph_rst_o  (prst),
      .sys_rst_req_o (sreq)
   );

   function automatic logic [NP-1:0] exp_periph(input logic we, input logic [31:0] d);
      if (!we)        return '0;
      if (d[30])      return SOFT_M;
      if (d[29])      return PER_M;
      return d[NP-1:0];
   endfunction

   function automatic logic exp_sys(input logic we, input logic [31:0] d);
      return we & d[31];
   endfunction

   task automatic check(input string tag, input logic we, input logic [31:0] d);
      logic [NP-1:0] ep;
      logic          es;
      ep = exp_periph(we, d);
      es = exp_sys(we, d);
      n_cmp++;
      if (prst !== ep || sreq !== es || rd_data !== 32'h0) begin
         n_bad++;
         $display("FAIL %s: periph=%h sys=%b rd=%h expected periph=%h sys=%b rd=0",
                  tag, prst, sreq, rd_data, ep, es);
      end
   endtask

   // Drive at a falling edge, check at the next falling edge (one register stage).
   task automatic apply(input string tag, input logic we, input logic [31:0] d);
      @(negedge clk);
      wr_en   = we;
      wr_data = d;
      @(negedge clk);
      check(tag, we, d);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      void'($urandom(32'h5EED_0042));
      // R1: outputs during reset, with a write attempt that must be ignored
      wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
      repeat (3) @(negedge clk);
      check("R1 in reset", 1'b0, 32'h0);
      wr_en = 1'b0;
      rst_ni = 1'b1;
      @(negedge clk);
      check("R1 after release", 1'b0, 32'h0);

      apply("R2 system bit", 1'b1, 32'h8000_0000);
      apply("R8 drop after system pulse", 1'b0, 32'h0);
      apply("R3 peripheral group", 1'b1, 32'h2000_0000);
      apply("R4 soft group", 1'b1, 32'h4000_0000);
      apply("R5 both groups soft wins", 1'b1, 32'h6000_0000);
      apply("R5 peripheral group replaces bits", 1'b1, 32'h2001_8000);
      apply("R5 soft group replaces bits", 1'b1, 32'h4000_2000);
      apply("R6 single UART1", 1'b1, 32'h0000_0002);
      apply("R6 single GPIO1", 1'b1, 32'h0001_0000);
      apply("R6 single WDT0", 1'b1, 32'h0000_2000);
      apply("R7 high field ignored", 1'b1, 32'h1FFE_0000);
      apply("R10 system with soft group", 1'b1, 32'hC000_0001);
      apply("R10 system with single bits", 1'b1, 32'h8000_0421);
      apply("R8 idle one", 1'b0, 32'hFFFF_FFFF);
      apply("R8 idle two", 1'b0, 32'h0);
      apply("R9 zero write", 1'b1, 32'h0);

      for (int i = 0; i < 400; i++) begin
         r = $urandom();
         case ($urandom_range(0, 3))
            0: r[30:29] = 2'b00;
            1: r[30:29] = 2'b01;
            2: r[30:29] = 2'b10;
            default: ;
         endcase
         apply("R6/R5/R10 random", ($urandom_range(0, 3) != 0), r);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule